// File: doc/BRIEF.md
# Supervisor Counter-Inhibit Alias

This block owns the machine-level counter-inhibit register. Each bit stops one hardware counter. It also gives supervisor software a filtered window onto that register. Machine-level reads and writes reach every implemented bit. Supervisor reads and writes reach only the bits whose counters machine software has handed down through the per-counter enable mask. The block drives the stored inhibit vector straight to the counter logic.

Supervisor accesses are checked against the current privilege mode and the global delegation-enable bit:

- Accesses that are not allowed are refused with an illegal-instruction code or a virtual-instruction code.
- A refused access leaves the stored register untouched.

Counting itself happens elsewhere.

Top module: `cnt_inhibit_alias`

## Requirements
- R1: After reset the inhibit vector and every read view are all zero.
- R2: A machine write (`m_wr_i`) stores `wdata_i` into every implemented bit. The stored value appears on `inhibit_o` after the next rising clock edge. A machine read (`m_rd_i`) returns the stored vector on `rdata_o` in the same cycle.
- R3: A permitted supervisor read (`s_rd_i`) returns the stored vector ANDed with `cnt_en_i`. Bits whose counters are not delegated read as zero.
- R4: A permitted supervisor write (`s_wr_i`) changes only the bits where `cnt_en_i` is 1. All other stored bits keep their value.
- R5: When `deleg_en_i` is 0, any supervisor access in any mode reports `exc_o` = 2'b01 (illegal instruction).
- R6: When `deleg_en_i` is 1, a supervisor access from VS mode (`mode_i` = 3'b101) or VU mode (`mode_i` = 3'b100) reports `exc_o` = 2'b10 (virtual instruction).
- R7: When `deleg_en_i` is 1, a supervisor access from U mode (3'b000) or from an unused mode code reports `exc_o` = 2'b01. M mode (3'b011) and S mode (3'b001) are permitted and report 2'b00.
- R8: A supervisor access that reports an exception leaves the stored vector unchanged and returns zero read data.
- R9: Bit 1 (the real-time timer position) always reads as zero and cannot be set through either view.
- R10: If a machine write and a supervisor write arrive in the same cycle, only the machine write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Privilege mode: 000 U, 001 S, 011 M, 100 VU, 101 VS |
| deleg_en_i | input | 1 | Global counter-delegation enable |
| cnt_en_i | input | 32 | Per-counter delegation mask |
| m_rd_i | input | 1 | Machine-view read strobe |
| m_wr_i | input | 1 | Machine-view write strobe |
| s_rd_i | input | 1 | Supervisor-view read strobe |
| s_wr_i | input | 1 | Supervisor-view write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the active read strobe |
| exc_o | output | 2 | 00 none, 01 illegal instruction, 10 virtual instruction |
| inhibit_o | output | 32 | Stored inhibit vector to the counters |

## Verification
On every cycle, the assertions check the following:

- The timer bit stays at zero.
- The exception code follows the mode and enable rules.
- A refused supervisor write leaves the inhibit vector steady.
- A supervisor write never disturbs an undelegated bit.
- Supervisor read data never shows an undelegated bit.

Only the directed scenarios show that the right data values land in storage. They also show that a machine write wins over a simultaneous supervisor write, and that mixed delegation masks produce the exact expected read-back words.

// File: rtl/cinh_pkg.sv
package cinh_pkg;
    localparam logic [2:0] MODE_U  = 3'b000;
    localparam logic [2:0] MODE_S  = 3'b001;
    localparam logic [2:0] MODE_M  = 3'b011;
    localparam logic [2:0] MODE_VU = 3'b100;
    localparam logic [2:0] MODE_VS = 3'b101;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'b00,
        EXC_ILLEGAL = 2'b01,
        EXC_VIRTUAL = 2'b10
    } exc_kind_e;
endpackage

// File: rtl/cinh_access_check.sv
module cinh_access_check
    import cinh_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       deleg_en_i,
    input  logic       s_acc_i,
    output exc_kind_e  exc_o
);
    always_comb begin
        exc_o = EXC_NONE;
        if (s_acc_i) begin
            if (!deleg_en_i) begin
                exc_o = EXC_ILLEGAL;
            end else begin
                unique case (mode_i)
                    MODE_M, MODE_S:   exc_o = EXC_NONE;
                    MODE_VS, MODE_VU: exc_o = EXC_VIRTUAL;
                    default:          exc_o = EXC_ILLEGAL;
                endcase
            end
        end
    end
endmodule

// File: rtl/cinh_mask.sv
module cinh_mask #(
    parameter int unsigned            NCNT = 32,
    parameter logic [NCNT-1:0]        LIVE = '1
) (
    input  logic [NCNT-1:0] cnt_en_i,
    input  logic [NCNT-1:0] inh_i,
    output logic [NCNT-1:0] s_wmask_o,
    output logic [NCNT-1:0] s_view_o
);
    for (genvar i = 0; i < NCNT; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            assign s_wmask_o[i] = cnt_en_i[i];
            assign s_view_o[i]  = cnt_en_i[i] & inh_i[i];
        end else begin : g_dead
            assign s_wmask_o[i] = 1'b0;
            assign s_view_o[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/cnt_inhibit_alias.sv
module cnt_inhibit_alias
    import cinh_pkg::*;
#(
    parameter int unsigned     NCNT      = 32,
    parameter logic [NCNT-1:0] IMPL_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode_i,
    input  logic            deleg_en_i,
    input  logic [NCNT-1:0] cnt_en_i,
    input  logic            m_rd_i,
    input  logic            m_wr_i,
    input  logic            s_rd_i,
    input  logic            s_wr_i,
    input  logic [NCNT-1:0] wdata_i,
    output logic [NCNT-1:0] rdata_o,
    output logic [1:0]      exc_o,
    output logic [NCNT-1:0] inhibit_o
);
    localparam logic [NCNT-1:0] TIMER_ONEHOT = NCNT'(2);
    localparam logic [NCNT-1:0] LIVE         = IMPL_MASK & ~TIMER_ONEHOT;

    typedef struct packed {
        logic [NCNT-1:0] inh;
    } state_t;

    state_t          state_d, state_q;
    exc_kind_e       exc;
    logic [NCNT-1:0] s_wmask, s_view;
    logic            s_ok;

    cinh_access_check i_check (
        .mode_i     (mode_i),
        .deleg_en_i (deleg_en_i),
        .s_acc_i    (s_rd_i | s_wr_i),
        .exc_o      (exc)
    );

    cinh_mask #(.NCNT(NCNT), .LIVE(LIVE)) i_mask (
        .cnt_en_i  (cnt_en_i),
        .inh_i     (state_q.inh),
        .s_wmask_o (s_wmask),
        .s_view_o  (s_view)
    );

    assign s_ok = (exc == EXC_NONE);

    always_comb begin
        state_d = state_q;
        rdata_o = '0;
        if (m_wr_i) begin
            state_d.inh = wdata_i & LIVE;
        end else if (s_wr_i && s_ok) begin
            state_d.inh = (state_q.inh & ~s_wmask) | (wdata_i & s_wmask);
        end
        if (m_rd_i) begin
            rdata_o = state_q.inh;
        end else if (s_rd_i && s_ok) begin
            rdata_o = s_view;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign inhibit_o = state_q.inh;
    assign exc_o     = exc;

    p_timer_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o[1] == 1'b0);

    p_cde_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_rd_i || s_wr_i) && !deleg_en_i) |-> exc_o == 2'b01);

    p_guest_virt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_rd_i || s_wr_i) && deleg_en_i &&
         (mode_i == MODE_VS || mode_i == MODE_VU)) |-> exc_o == 2'b10);

    p_refused_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr_i && !m_wr_i && exc_o != 2'b00) |=> $stable(inhibit_o));

    p_undeleg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr_i && !m_wr_i) |=>
        ((inhibit_o ^ $past(inhibit_o)) & ~$past(cnt_en_i)) == '0);

    p_sread_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd_i && !m_rd_i) |-> (rdata_o & ~cnt_en_i) == '0);
endmodule

// File: tb/test_cnt_inhibit_alias.sv
module test_cnt_inhibit_alias;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'b011;
    logic        deleg_en_i = 1'b0;
    logic [31:0] cnt_en_i = '0;
    logic        m_rd_i = 1'b0, m_wr_i = 1'b0, s_rd_i = 1'b0, s_wr_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o, inhibit_o;
    logic [1:0]  exc_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model;

    always #2 clk = ~clk;

    cnt_inhibit_alias i_cnt_inhibit_alias (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .deleg_en_i(deleg_en_i),
        .cnt_en_i(cnt_en_i), .m_rd_i(m_rd_i), .m_wr_i(m_wr_i), .s_rd_i(s_rd_i),
        .s_wr_i(s_wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .exc_o(exc_o),
        .inhibit_o(inhibit_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mwr(input logic [31:0] d);
        @(negedge clk); m_wr_i = 1'b1; wdata_i = d;
        @(negedge clk); m_wr_i = 1'b0; #1;
    endtask

    task automatic mrd(output logic [31:0] r);
        @(negedge clk); m_rd_i = 1'b1; #1; r = rdata_o;
        @(negedge clk); m_rd_i = 1'b0; #1;
    endtask

    task automatic sacc(input logic rd, input logic wr, input logic [2:0] md,
                        input logic [31:0] d, output logic [1:0] e, output logic [31:0] r);
        @(negedge clk); mode_i = md; s_rd_i = rd; s_wr_i = wr; wdata_i = d;
        #1; e = exc_o; r = rdata_o;
        @(negedge clk); s_rd_i = 1'b0; s_wr_i = 1'b0; mode_i = 3'b011; #1;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 inhibit after reset", inhibit_o, 32'h0);
        mrd(r);
        check("R1 machine read after reset", r, 32'h0);
    endtask

    task automatic t_machine();
        logic [31:0] r;
        mwr(32'hA5A5_5A5A); model = 32'hA5A5_5A58;
        check("R2 R9 inhibit after machine write", inhibit_o, model);
        mrd(r);
        check("R2 machine read", r, model);
        mwr(32'hFFFF_FFFF); model = 32'hFFFF_FFFD;
        check("R9 timer bit stays zero", inhibit_o, model);
    endtask

    task automatic t_sread();
        logic [1:0] e; logic [31:0] r;
        deleg_en_i = 1'b1; cnt_en_i = 32'h0000_FF0F;
        sacc(1'b1, 1'b0, 3'b001, '0, e, r);
        check("R3 exc on S read", {30'h0, e}, 32'h0);
        check("R3 S read masked", r, model & 32'h0000_FF0D);
        cnt_en_i = 32'hFFFF_FFFF;
        sacc(1'b1, 1'b0, 3'b011, '0, e, r);
        check("R9 R7 M-mode alias read", r, 32'hFFFF_FFFD);
    endtask

    task automatic t_swrite();
        logic [1:0] e; logic [31:0] r;
        cnt_en_i = 32'h00F0_00F2;
        sacc(1'b0, 1'b1, 3'b001, 32'h0000_0000, e, r);
        model = model & ~32'h00F0_00F0;
        check("R4 S write clears delegated only", inhibit_o, model);
        sacc(1'b0, 1'b1, 3'b001, 32'hFFFF_FFFF, e, r);
        model = model | 32'h00F0_00F0;
        check("R4 R9 S write sets delegated only", inhibit_o, model);
    endtask

    task automatic t_exc_cde();
        logic [1:0] e; logic [31:0] r;
        mwr(32'h0000_1234); model = 32'h0000_1234;
        deleg_en_i = 1'b0; cnt_en_i = 32'hFFFF_FFFF;
        sacc(1'b1, 1'b0, 3'b011, '0, e, r);
        check("R5 M mode disabled", {30'h0, e}, 32'h1);
        check("R8 refused read data", r, 32'h0);
        sacc(1'b0, 1'b1, 3'b101, 32'hFFFF_0000, e, r);
        check("R5 VS mode disabled", {30'h0, e}, 32'h1);
        check("R8 refused write keeps storage", inhibit_o, model);
    endtask

    task automatic t_exc_virt();
        logic [1:0] e; logic [31:0] r;
        deleg_en_i = 1'b1;
        sacc(1'b0, 1'b1, 3'b101, 32'hFFFF_0000, e, r);
        check("R6 VS virtual", {30'h0, e}, 32'h2);
        check("R8 VS write keeps storage", inhibit_o, model);
        sacc(1'b1, 1'b0, 3'b100, '0, e, r);
        check("R6 VU virtual", {30'h0, e}, 32'h2);
    endtask

    task automatic t_exc_user();
        logic [1:0] e; logic [31:0] r;
        sacc(1'b0, 1'b1, 3'b000, 32'hFFFF_0000, e, r);
        check("R7 U illegal", {30'h0, e}, 32'h1);
        check("R8 U write keeps storage", inhibit_o, model);
        sacc(1'b1, 1'b0, 3'b110, '0, e, r);
        check("R7 unused mode illegal", {30'h0, e}, 32'h1);
    endtask

    task automatic t_priority();
        deleg_en_i = 1'b1; cnt_en_i = 32'hFFFF_FFFF;
        @(negedge clk); mode_i = 3'b001; m_wr_i = 1'b1; s_wr_i = 1'b1; wdata_i = 32'h0F0F_0F0F;
        @(negedge clk); m_wr_i = 1'b0; s_wr_i = 1'b0; #1;
        check("R10 both writes, machine data", inhibit_o, 32'h0F0F_0F0D);
        cnt_en_i = 32'h0000_0000; deleg_en_i = 1'b1;
        @(negedge clk); m_wr_i = 1'b1; s_wr_i = 1'b1; wdata_i = 32'hF000_0001;
        @(negedge clk); m_wr_i = 1'b0; s_wr_i = 1'b0; #1;
        check("R10 machine write ignores mask", inhibit_o, 32'hF000_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        t_reset();
        t_machine();
        t_sread();
        t_swrite();
        t_exc_cde();
        t_exc_virt();
        t_exc_user();
        t_priority();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule